// File: doc/BRIEF.md
# Inner Edge Deblocking Filter

This block smooths the pixels on both sides of a block boundary. Each beat carries sixteen lanes. Each lane holds one line of eight unsigned pixels that crosses the edge: four on the near side (`p3`..`p0`, with `p0` next to the edge) and four on the far side (`q0`..`q3`). For every lane the block decides whether the step at the edge looks like a coding artefact. It then pulls the two pixels nearest the edge toward each other and, in normal mode, the next pair too. The block returns the four inner pixels (`p1`, `p0`, `q0`, `q1`), updated.

Three thresholds govern the decisions:
- an interior limit, against which the neighbour-to-neighbour steps inside each side are compared;
- an edge limit, against which the step across the edge is compared;
- a variance threshold, which marks lanes with high activity next to the edge.

The thresholds belong to an edge. The block takes them on the beat flagged as the first beat of that edge and holds them for the beats that follow. A per-beat mode bit selects a simpler filter. That filter looks only at the step across the edge and changes only `p0` and `q0`.

The datapath has two register stages. The first stage registers the per-lane decisions together with the four inner pixels. The second stage registers the filtered pixels. A valid bit runs alongside the data. All arithmetic treats pixels as signed bytes: the top bit is flipped on the way in and flipped back on the way out, and every add and subtract clamps to the range -128..127.

Top module: `edge_deblock`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is low.
- R2: A beat presented with `in_valid` high on clock edge N appears with `out_valid` high after edge N+2. Beats come out in order, one output per input, and idle cycles between beats are allowed.
- R3: In normal mode, a lane is marked high-variance when max(|p1-p0|, |q1-q0|) is strictly greater than the variance threshold. In such a lane `out_p1` and `out_q1` equal the input `p1` and `q1`.
- R4: In normal mode, a lane is left unchanged (all four outputs equal their inputs) when the largest of |p3-p2|, |p2-p1|, |p1-p0|, |q1-q0|, |q2-q1| and |q3-q2| exceeds the interior limit, or when |p0-q0| exceeds the edge limit.
- R5: With signed pixels s = x XOR 0x80, the block forms a = clamp(clamp(clamp(t+d)+d)+d), where d = clamp(q0-p0). The term t is clamp(p1-q1) for a high-variance lane and 0 otherwise, and a is 0 for a suppressed lane. The block then takes f1 = clamp(a+4)>>>3 and f2 = clamp(a+3)>>>3, and outputs q0 as clamp(q0-f1) and p0 as clamp(p0+f2).
- R6: In normal mode, for a lane that is not high-variance, u = (f1+1)>>>1, `out_q1` = clamp(q1-u) and `out_p1` = clamp(p1+u).
- R7: When `in_simple` is 1, only |p0-q0| against the edge limit decides suppression, and `out_p1` and `out_q1` equal the input `p1` and `q1`.
- R8: When `in_simple` is 1, t = clamp(p1-q1) in every lane, whatever the variance.
- R9: The three thresholds are sampled on a valid beat with `in_first` = 1, and that beat uses them. Beats with `in_first` = 0 use the values last sampled and ignore the threshold inputs.
- R10: Lane i occupies bits [8i+7:8i] of every pixel bus, and its result depends only on that lane's pixels.
- R11: Every intermediate result clamps to a signed byte, so extreme inputs (0 against 255) give clamped, not wrapped, results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on the inputs |
| in_first | input | 1 | First beat of an edge; samples the thresholds |
| in_simple | input | 1 | 1 selects the simple filter for this beat |
| thr_limit | input | 8 | Interior step limit |
| thr_edge | input | 8 | Step limit across the edge |
| thr_hev | input | 8 | High-variance threshold |
| in_p3 | input | 8*LANES | Farthest near-side pixel, per lane |
| in_p2 | input | 8*LANES | Near-side pixel 2 |
| in_p1 | input | 8*LANES | Near-side pixel 1 |
| in_p0 | input | 8*LANES | Near-side pixel at the edge |
| in_q0 | input | 8*LANES | Far-side pixel at the edge |
| in_q1 | input | 8*LANES | Far-side pixel 1 |
| in_q2 | input | 8*LANES | Far-side pixel 2 |
| in_q3 | input | 8*LANES | Farthest far-side pixel |
| out_valid | output | 1 | Filtered beat present on the outputs |
| out_p1 | output | 8*LANES | Filtered p1 |
| out_p0 | output | 8*LANES | Filtered p0 |
| out_q0 | output | 8*LANES | Filtered q0 |
| out_q1 | output | 8*LANES | Filtered q1 |

## Verification
All four pixel results of a beat arrive together, two clock edges after the edge that accepts the beat. No result is produced before then.

The bench drives each beat half a cycle before its capturing edge. It records the cycle count and the model's expected pixels in a scoreboard slot. It reads `out_valid` and the outputs half a cycle after edges, and checks that each result lands exactly two counts after its beat. The scoreboard pairs results with beats in order, so a gap or an extra `out_valid` shows up as a latency or count mismatch. The checker applies the same two-edge offset in its `$past` terms, enabled only once two edges have passed since reset.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Pixel width; the saturation arithmetic below is byte-wide by definition.
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic signed [PIX_W-1:0] spix_t;
  typedef logic signed [PIX_W+1:0] wide_t;

  // Unsigned subtraction that floors at zero.
  function automatic pix_t floor_sub(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : '0;
  endfunction

  // Absolute difference built from two floored subtractions.
  function automatic pix_t abs_step(input pix_t a, input pix_t b);
    return floor_sub(a, b) | floor_sub(b, a);
  endfunction

  function automatic pix_t max_u(input pix_t a, input pix_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic wide_t widen(input spix_t a);
    return $signed({{2{a[PIX_W-1]}}, a});
  endfunction

  function automatic spix_t clamp_s(input wide_t x);
    if (x > wide_t'(127))
      return spix_t'(8'h7F);
    else if (x < -wide_t'(128))
      return spix_t'(8'h80);
    else
      return spix_t'(x[PIX_W-1:0]);
  endfunction

  function automatic spix_t add_sat(input spix_t a, input spix_t b);
    return clamp_s(widen(a) + widen(b));
  endfunction

  function automatic spix_t sub_sat(input spix_t a, input spix_t b);
    return clamp_s(widen(a) - widen(b));
  endfunction

endpackage

// File: rtl/dbf_decide.sv
module dbf_decide
  import dbf_pkg::*;
(
  input  pix_t p3,
  input  pix_t p2,
  input  pix_t p1,
  input  pix_t p0,
  input  pix_t q0,
  input  pix_t q1,
  input  pix_t q2,
  input  pix_t q3,
  input  pix_t lim,
  input  pix_t edg,
  input  pix_t hvt,
  input  logic simple_mode,
  output logic hev,
  output logic hold
);

  pix_t near_act;
  pix_t inner_max;
  logic edge_over;
  logic inner_over;

  always_comb begin
    near_act   = max_u(abs_step(p1, p0), abs_step(q1, q0));
    inner_max  = max_u(near_act,
                   max_u(max_u(abs_step(p3, p2), abs_step(p2, p1)),
                         max_u(abs_step(q2, q1), abs_step(q3, q2))));
    edge_over  = abs_step(p0, q0) > edg;
    inner_over = inner_max > lim;
    hev        = near_act > hvt;
    hold       = simple_mode ? edge_over : (edge_over | inner_over);
  end

endmodule

// File: rtl/dbf_lane_filter.sv
module dbf_lane_filter
  import dbf_pkg::*;
(
  input  pix_t p1,
  input  pix_t p0,
  input  pix_t q0,
  input  pix_t q1,
  input  logic hev,
  input  logic hold,
  input  logic simple_mode,
  output pix_t np1,
  output pix_t np0,
  output pix_t nq0,
  output pix_t nq1
);

  localparam pix_t SIGN_FLIP = pix_t'(1) << (PIX_W - 1);

  spix_t sp1, sp0, sq0, sq1;
  spix_t outer, step, acc;
  spix_t f1, f2, u;
  spix_t rp1, rp0, rq0, rq1;

  always_comb begin
    sp1   = spix_t'(p1 ^ SIGN_FLIP);
    sp0   = spix_t'(p0 ^ SIGN_FLIP);
    sq0   = spix_t'(q0 ^ SIGN_FLIP);
    sq1   = spix_t'(q1 ^ SIGN_FLIP);

    outer = (simple_mode | hev) ? sub_sat(sp1, sq1) : spix_t'(0);
    step  = sub_sat(sq0, sp0);
    acc   = add_sat(add_sat(add_sat(outer, step), step), step);
    if (hold)
      acc = spix_t'(0);

    f1    = add_sat(acc, spix_t'(4)) >>> 3;
    f2    = add_sat(acc, spix_t'(3)) >>> 3;
    rq0   = sub_sat(sq0, f1);
    rp0   = add_sat(sp0, f2);

    // f1 lies in -16..15, so the increment cannot wrap.
    u     = (f1 + spix_t'(1)) >>> 1;
    if (!simple_mode && !hev) begin
      rq1 = sub_sat(sq1, u);
      rp1 = add_sat(sp1, u);
    end else begin
      rq1 = sq1;
      rp1 = sp1;
    end

    np1 = pix_t'(rp1) ^ SIGN_FLIP;
    np0 = pix_t'(rp0) ^ SIGN_FLIP;
    nq0 = pix_t'(rq0) ^ SIGN_FLIP;
    nq1 = pix_t'(rq1) ^ SIGN_FLIP;
  end

endmodule

// File: rtl/edge_deblock.sv
module edge_deblock
  import dbf_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic                   in_simple,
  input  logic [PIX_W-1:0]       thr_limit,
  input  logic [PIX_W-1:0]       thr_edge,
  input  logic [PIX_W-1:0]       thr_hev,
  input  logic [LANES*PIX_W-1:0] in_p3,
  input  logic [LANES*PIX_W-1:0] in_p2,
  input  logic [LANES*PIX_W-1:0] in_p1,
  input  logic [LANES*PIX_W-1:0] in_p0,
  input  logic [LANES*PIX_W-1:0] in_q0,
  input  logic [LANES*PIX_W-1:0] in_q1,
  input  logic [LANES*PIX_W-1:0] in_q2,
  input  logic [LANES*PIX_W-1:0] in_q3,
  output logic                   out_valid,
  output logic [LANES*PIX_W-1:0] out_p1,
  output logic [LANES*PIX_W-1:0] out_p0,
  output logic [LANES*PIX_W-1:0] out_q0,
  output logic [LANES*PIX_W-1:0] out_q1
);

  localparam int VW = LANES * PIX_W;

  // Per-edge thresholds, with bypass on the first beat of an edge.
  pix_t held_lim, held_edg, held_hvt;
  pix_t use_lim, use_edg, use_hvt;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_lim <= '0;
      held_edg <= '0;
      held_hvt <= '0;
    end else if (in_valid && in_first) begin
      held_lim <= thr_limit;
      held_edg <= thr_edge;
      held_hvt <= thr_hev;
    end
  end

  always_comb begin
    use_lim = in_first ? thr_limit : held_lim;
    use_edg = in_first ? thr_edge  : held_edg;
    use_hvt = in_first ? thr_hev   : held_hvt;
  end

  // Stage 1: decisions plus the pixels that may change.
  logic [LANES-1:0] dec_hev, dec_hold;
  logic             s1_valid, s1_simple;
  logic [LANES-1:0] s1_hev, s1_hold;
  logic [VW-1:0]    s1_p1, s1_p0, s1_q0, s1_q1;

  // Stage 2 combinational results.
  logic [VW-1:0]    nx_p1, nx_p0, nx_q0, nx_q1;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    dbf_decide u_decide (
      .p3          (in_p3[ln*PIX_W +: PIX_W]),
      .p2          (in_p2[ln*PIX_W +: PIX_W]),
      .p1          (in_p1[ln*PIX_W +: PIX_W]),
      .p0          (in_p0[ln*PIX_W +: PIX_W]),
      .q0          (in_q0[ln*PIX_W +: PIX_W]),
      .q1          (in_q1[ln*PIX_W +: PIX_W]),
      .q2          (in_q2[ln*PIX_W +: PIX_W]),
      .q3          (in_q3[ln*PIX_W +: PIX_W]),
      .lim         (use_lim),
      .edg         (use_edg),
      .hvt         (use_hvt),
      .simple_mode (in_simple),
      .hev         (dec_hev[ln]),
      .hold        (dec_hold[ln])
    );

    dbf_lane_filter u_filter (
      .p1          (s1_p1[ln*PIX_W +: PIX_W]),
      .p0          (s1_p0[ln*PIX_W +: PIX_W]),
      .q0          (s1_q0[ln*PIX_W +: PIX_W]),
      .q1          (s1_q1[ln*PIX_W +: PIX_W]),
      .hev         (s1_hev[ln]),
      .hold        (s1_hold[ln]),
      .simple_mode (s1_simple),
      .np1         (nx_p1[ln*PIX_W +: PIX_W]),
      .np0         (nx_p0[ln*PIX_W +: PIX_W]),
      .nq0         (nx_q0[ln*PIX_W +: PIX_W]),
      .nq1         (nx_q1[ln*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_simple <= in_simple;
      s1_hev    <= dec_hev;
      s1_hold   <= dec_hold;
      s1_p1     <= in_p1;
      s1_p0     <= in_p0;
      s1_q0     <= in_q0;
      s1_q1     <= in_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_p1 <= nx_p1;
      out_p0 <= nx_p0;
      out_q0 <= nx_q0;
      out_q1 <= nx_q1;
    end
  end

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker
  import dbf_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_simple,
  input logic [LANES*PIX_W-1:0] in_p1,
  input logic [LANES*PIX_W-1:0] in_p0,
  input logic [LANES*PIX_W-1:0] in_q0,
  input logic [LANES*PIX_W-1:0] in_q1,
  input logic                   out_valid,
  input logic [LANES*PIX_W-1:0] out_p1,
  input logic [LANES*PIX_W-1:0] out_p0,
  input logic [LANES*PIX_W-1:0] out_q0,
  input logic [LANES*PIX_W-1:0] out_q1
);

  logic [1:0] arm_cnt = 2'd0;
  logic       armed;
  logic       was_rst = 1'b0;

  always_ff @(posedge clk) begin
    if (rst)                 arm_cnt <= 2'd0;
    else if (arm_cnt != 2'd2) arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed = (arm_cnt == 2'd2);

  always_ff @(posedge clk) was_rst <= rst;

  always @(posedge clk) begin
    if (was_rst) begin
      p_reset_quiet_r1: assert (!out_valid)
        else $error("out_valid high right after reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid, 2)));

  p_simple_outer_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid && $past(in_simple, 2)) |->
      (out_p1 == $past(in_p1, 2)) && (out_q1 == $past(in_q1, 2)));

  for (genvar ln = 0; ln < LANES; ln++) begin : g_chk
    p_opposite_r5: assert property (@(posedge clk) disable iff (rst)
      (armed && out_valid) |->
        !((out_p0[ln*PIX_W +: PIX_W] > $past(in_p0[ln*PIX_W +: PIX_W], 2)) &&
          (out_q0[ln*PIX_W +: PIX_W] > $past(in_q0[ln*PIX_W +: PIX_W], 2))) &&
        !((out_p0[ln*PIX_W +: PIX_W] < $past(in_p0[ln*PIX_W +: PIX_W], 2)) &&
          (out_q0[ln*PIX_W +: PIX_W] < $past(in_q0[ln*PIX_W +: PIX_W], 2))));

    p_p0_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (armed && out_valid) |->
        (abs_step(out_p0[ln*PIX_W +: PIX_W], $past(in_p0[ln*PIX_W +: PIX_W], 2))
           <= pix_t'(16)));

    p_p1_bound_r6: assert property (@(posedge clk) disable iff (rst)
      (armed && out_valid) |->
        (abs_step(out_p1[ln*PIX_W +: PIX_W], $past(in_p1[ln*PIX_W +: PIX_W], 2))
           <= pix_t'(8)));
  end

endmodule

bind edge_deblock dbf_checker #(.LANES(LANES)) u_dbf_chk (.*);

// File: tb/test_edge_deblock.sv
module test_edge_deblock;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int VW         = LANES * 8;
  localparam int SLOTS      = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0, in_simple = 1'b0;
  logic [7:0] thr_limit = '0, thr_edge = '0, thr_hev = '0;
  logic [VW-1:0] in_p3 = '0, in_p2 = '0, in_p1 = '0, in_p0 = '0;
  logic [VW-1:0] in_q0 = '0, in_q1 = '0, in_q2 = '0, in_q3 = '0;
  logic          out_valid;
  logic [VW-1:0] out_p1, out_p0, out_q0, out_q1;

  edge_deblock #(.LANES(LANES)) i_edge_deblock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_simple(in_simple), .thr_limit(thr_limit), .thr_edge(thr_edge),
    .thr_hev(thr_hev), .in_p3(in_p3), .in_p2(in_p2), .in_p1(in_p1),
    .in_p0(in_p0), .in_q0(in_q0), .in_q1(in_q1), .in_q2(in_q2),
    .in_q3(in_q3), .out_valid(out_valid), .out_p1(out_p1),
    .out_p0(out_p0), .out_q0(out_q0), .out_q1(out_q1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard
  logic [VW-1:0] e_p1 [SLOTS];
  logic [VW-1:0] e_p0 [SLOTS];
  logic [VW-1:0] e_q0 [SLOTS];
  logic [VW-1:0] e_q1 [SLOTS];
  int            e_cyc [SLOTS];
  string         e_tag [SLOTS];
  int wr_idx = 0;
  int rd_idx = 0;

  // Bench copy of the per-edge thresholds
  logic [7:0] b_lim = '0, b_edg = '0, b_hvt = '0;

  task automatic chk(input string tag, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sat8(input int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  function automatic int adiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Returns {p1, p0, q0, q1} for one lane
  function automatic logic [31:0] ref_lane(
      input logic [7:0] p3, input logic [7:0] p2, input logic [7:0] p1, input logic [7:0] p0,
      input logic [7:0] q0, input logic [7:0] q1, input logic [7:0] q2, input logic [7:0] q3,
      input logic [7:0] lim, input logic [7:0] edg, input logic [7:0] hvt, input bit simple);
    int near, inner, t, d, a, f1, f2, u;
    int sp1, sp0, sq0, sq1, np1, np0, nq0, nq1;
    bit hev, sup;
    near  = max2(adiff(p1, p0), adiff(q1, q0));
    inner = max2(near, max2(max2(adiff(p3, p2), adiff(p2, p1)),
                            max2(adiff(q2, q1), adiff(q3, q2))));
    hev = near > int'(hvt);
    if (simple) sup = adiff(p0, q0) > int'(edg);
    else        sup = (adiff(p0, q0) > int'(edg)) || (inner > int'(lim));
    sp1 = int'(p1) - 128; sp0 = int'(p0) - 128;
    sq0 = int'(q0) - 128; sq1 = int'(q1) - 128;
    t = (simple || hev) ? sat8(sp1 - sq1) : 0;
    d = sat8(sq0 - sp0);
    a = sat8(sat8(sat8(t + d) + d) + d);
    if (sup) a = 0;
    f1 = sat8(a + 4) >>> 3;
    f2 = sat8(a + 3) >>> 3;
    nq0 = sat8(sq0 - f1);
    np0 = sat8(sp0 + f2);
    np1 = sp1; nq1 = sq1;
    if (!simple && !hev) begin
      u = (f1 + 1) >>> 1;
      nq1 = sat8(sq1 - u);
      np1 = sat8(sp1 + u);
    end
    return {8'(np1 + 128), 8'(np0 + 128), 8'(nq0 + 128), 8'(nq1 + 128)};
  endfunction

  task automatic drive(input bit first, input bit simple,
                       input logic [7:0] lim, input logic [7:0] edg, input logic [7:0] hvt,
                       input logic [VW-1:0] p3, input logic [VW-1:0] p2,
                       input logic [VW-1:0] p1, input logic [VW-1:0] p0,
                       input logic [VW-1:0] q0, input logic [VW-1:0] q1,
                       input logic [VW-1:0] q2, input logic [VW-1:0] q3,
                       input string tag);
    logic [31:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_first = first; in_simple = simple;
    thr_limit = lim; thr_edge = edg; thr_hev = hvt;
    in_p3 = p3; in_p2 = p2; in_p1 = p1; in_p0 = p0;
    in_q0 = q0; in_q1 = q1; in_q2 = q2; in_q3 = q3;
    if (first) begin b_lim = lim; b_edg = edg; b_hvt = hvt; end
    for (int ln = 0; ln < LANES; ln++) begin
      r = ref_lane(p3[ln*8 +: 8], p2[ln*8 +: 8], p1[ln*8 +: 8], p0[ln*8 +: 8],
                   q0[ln*8 +: 8], q1[ln*8 +: 8], q2[ln*8 +: 8], q3[ln*8 +: 8],
                   b_lim, b_edg, b_hvt, simple);
      e_p1[wr_idx][ln*8 +: 8] = r[31:24];
      e_p0[wr_idx][ln*8 +: 8] = r[23:16];
      e_q0[wr_idx][ln*8 +: 8] = r[15:8];
      e_q1[wr_idx][ln*8 +: 8] = r[7:0];
    end
    e_cyc[wr_idx] = cyc;
    e_tag[wr_idx] = tag;
    wr_idx++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_first = $urandom_range(0, 1);
    thr_limit = 8'($urandom); thr_edge = 8'($urandom); thr_hev = 8'($urandom);
  endtask

  task automatic flat(input bit first, input bit simple,
                      input logic [7:0] lim, input logic [7:0] edg, input logic [7:0] hvt,
                      input logic [7:0] a3, input logic [7:0] a2, input logic [7:0] a1,
                      input logic [7:0] a0, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3, input string tag);
    drive(first, simple, lim, edg, hvt,
          {LANES{a3}}, {LANES{a2}}, {LANES{a1}}, {LANES{a0}},
          {LANES{b0}}, {LANES{b1}}, {LANES{b2}}, {LANES{b3}}, tag);
  endtask

  // Output monitor: one result per beat, due two counts after its beat
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd_idx >= wr_idx) begin
        chk_int("R2", "unexpected out_valid", 1, 0);
      end else begin
        chk_int("R2", "latency", cyc, e_cyc[rd_idx] + 2);
        chk(e_tag[rd_idx], "p1", out_p1, e_p1[rd_idx]);
        chk(e_tag[rd_idx], "p0", out_p0, e_p0[rd_idx]);
        chk(e_tag[rd_idx], "q0", out_q0, e_q0[rd_idx]);
        chk(e_tag[rd_idx], "q1", out_q1, e_q1[rd_idx]);
        rd_idx++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [VW-1:0] v [8];
    int base, spread;
    void'($urandom(32'h5EED_D0B1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_int("R1", "out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_int("R1", "out_valid after reset", int'(out_valid), 0);

    // R5, R6: gentle step, filter applies to both pairs
    flat(1, 0, 20, 40, 5, 100, 100, 100, 100, 110, 110, 110, 110, "R6");
    // R3: high activity next to the edge keeps p1/q1
    flat(1, 0, 20, 40, 5, 100, 100, 90, 100, 110, 120, 110, 110, "R3");
    // R4: interior step above the limit
    flat(1, 0, 20, 40, 5, 10, 100, 100, 100, 110, 110, 110, 110, "R4");
    // R4: step across the edge above the edge limit
    flat(1, 0, 20, 40, 5, 100, 100, 100, 100, 160, 160, 160, 160, "R4");
    // R7, R8: simple mode, large interior steps, p1-q1 term active
    flat(1, 1, 5, 40, 0, 10, 200, 130, 100, 110, 80, 0, 255, "R8");
    flat(0, 1, 0, 0, 0, 10, 200, 130, 100, 110, 80, 0, 255, "R7");
    // R11: extreme values, normal and simple
    flat(1, 0, 255, 255, 255, 255, 255, 255, 0, 255, 0, 0, 0, "R11");
    flat(0, 1, 0, 0, 0, 255, 255, 255, 0, 255, 0, 0, 0, "R11");
    // R9: thresholds come from the first beat only
    flat(1, 0, 20, 40, 5, 100, 100, 100, 100, 110, 110, 110, 110, "R9");
    flat(0, 0, 0, 0, 0, 100, 100, 100, 100, 110, 110, 110, 110, "R9");
    idle();
    flat(0, 0, 255, 255, 255, 100, 100, 100, 100, 110, 110, 110, 110, "R9");
    // R10: one lane carries an edge, the rest are flat
    begin
      for (int k = 0; k < 8; k++) v[k] = {LANES{8'd50}};
      v[3][5*8 +: 8] = 8'd100; v[4][5*8 +: 8] = 8'd110;
      v[2][5*8 +: 8] = 8'd100; v[5][5*8 +: 8] = 8'd110;
      drive(1, 0, 80, 80, 5, v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7], "R10");
    end
    idle();
    idle();

    // Random beats around the decision thresholds
    for (int n = 0; n < 600; n++) begin
      for (int ln = 0; ln < LANES; ln++) begin
        base   = $urandom_range(0, 255);
        spread = ($urandom_range(0, 3) == 0) ? 255 : $urandom_range(1, 24);
        for (int k = 0; k < 8; k++) begin
          int pv;
          pv = base + int'($urandom_range(0, 2 * spread)) - spread;
          if (k >= 4 && $urandom_range(0, 1) == 1) pv = pv + 12;
          if (pv < 0) pv = 0;
          if (pv > 255) pv = 255;
          v[k][ln*8 +: 8] = 8'(pv);
        end
      end
      drive(($urandom_range(0, 4) == 0), ($urandom_range(0, 3) == 0),
            8'($urandom_range(0, 40)), 8'($urandom_range(0, 60)), 8'($urandom_range(0, 12)),
            v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7],
            ($urandom_range(0, 1) == 0) ? "R5" : "R6");
      if ($urandom_range(0, 5) == 0) idle();
    end

    idle();
    repeat (5) @(negedge clk);
    chk_int("R2", "results drained", rd_idx, wr_idx);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule